// File: doc/BRIEF.md
# Partition Power-Up Sequencer

This block is a hardware state machine that brings one power partition and the peripheral attached to it from off to running, always in the same order. A single-cycle start pulse carries the index of the partition. The sequencer first holds the peripheral in reset. It then makes sure the partition is powered. Next it enables the peripheral clock and waits a settle time. After that it asks the power controller to remove the isolation clamps and waits a second settle time. Last, it releases the reset. The power controller and the clock generator sit outside the block. The sequencer reaches them only through one-cycle request strobes and the index output, and it reads back one status bit per partition.

Both intervals are counts of clock cycles taken from parameters: the clock frequency in hertz, which must be a whole number of MHz, the settle time in microseconds (10 by default) and the power timeout in microseconds (25000 by default). If the partition is already powered when the sequence starts, no power toggle is sent. If the status bit does not come up inside the timeout window, the sequence stops. In that case the peripheral stays in reset, its clock is never enabled, and an error pulse is given. For historical reasons the clamp-removal mask swaps the bits of two chosen partitions.

Top module: `part_pwrup_seq`

## Requirements
- R1: After reset, busy_o, periph_rst_o and every strobe output (toggle_req_o, clk_en_o, unclamp_req_o, done_o, err_o) are low.
- R2: A start_i pulse while idle captures part_idx_i onto part_o and sets busy_o and periph_rst_o in the next cycle.
- R3: If the selected bit of part_stat_i is 1 in the first cycle after the start, no toggle request is issued and clk_en_o pulses in that same next cycle.
- R4: Otherwise toggle_req_o pulses exactly once, one cycle after busy_o rises. The sequencer then waits until the selected status bit reads 1, and clk_en_o pulses in the cycle after the bit is first seen.
- R5: If the selected status bit is still 0 at TIMEOUT_US times the clock rate in MHz cycles after the toggle pulse, err_o pulses in that cycle and busy_o drops. Neither clk_en_o nor unclamp_req_o pulses, and periph_rst_o stays high afterwards.
- R6: unclamp_req_o pulses exactly SETTLE_US times the clock rate in MHz cycles after clk_en_o.
- R7: While unclamp_req_o is high, unclamp_mask_o is one-hot at bit part_o. The exception is the pair SWAP_A and SWAP_B: a request for either one sets the other one's bit.
- R8: The same settle count after unclamp_req_o, done_o pulses, periph_rst_o drops and busy_o drops, all in the same cycle. periph_rst_o stays high from the start until then.
- R9: A start_i that arrives while busy_o is high is ignored. part_o and the timing of the sequence do not change.
- R10: Every strobe output is high for a single cycle per event, and at most one strobe is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request pulse |
| part_idx_i | input | IDX_W | Partition to bring up |
| part_stat_i | input | NUM_PARTS | Power status per partition, 1 = powered |
| part_o | output | IDX_W | Partition that the current or last sequence works on |
| periph_rst_o | output | 1 | Peripheral reset, active high |
| toggle_req_o | output | 1 | Power toggle request strobe |
| clk_en_o | output | 1 | Peripheral clock enable strobe |
| unclamp_req_o | output | 1 | Clamp removal request strobe |
| unclamp_mask_o | output | NUM_PARTS | Clamp removal bit mask |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Successful completion strobe |
| err_o | output | 1 | Power timeout strobe |

## Verification
The bench makes the status bit arrive at the first cycle of the timeout window, at the last cycle, one cycle too late, and never. A design with an off-by-one in its timeout counter would then time out on a partition that powered up in time, or enable the clock for one that did not. Pre-powered partitions check that no toggle is sent, and a design that always toggles would show a second toggle strobe. Both partitions of the swapped pair are brought up, so a design with a plain one-hot mask shows the wrong bit. Starts during a busy sequence with a different index are aimed at a design that restarts or re-latches its index.

// File: rtl/pwrup_pkg.sv
package pwrup_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_PWR,
    ST_SET_CLK,
    ST_SET_UNCL
  } seq_state_e;
endpackage

// File: rtl/pwrup_timer.sv
module pwrup_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             expired_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/pwrup_clamp_map.sv
module pwrup_clamp_map #(
  parameter int unsigned NUM_PARTS = 8,
  parameter int unsigned IDX_W     = 3,
  parameter int unsigned SWAP_A    = 3,
  parameter int unsigned SWAP_B    = 4
) (
  input  logic [IDX_W-1:0]     idx_i,
  output logic [NUM_PARTS-1:0] mask_o
);
  for (genvar g = 0; g < NUM_PARTS; g++) begin : g_bit
    // bit g is set by the partition that maps onto it
    localparam int unsigned SRC = (g == SWAP_A) ? SWAP_B :
                                  (g == SWAP_B) ? SWAP_A : g;
    assign mask_o[g] = (idx_i == IDX_W'(SRC));
  end
endmodule

// File: rtl/pwrup_ctrl.sv
module pwrup_ctrl
  import pwrup_pkg::*;
#(
  parameter int unsigned IDX_W   = 3,
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned SET_CYC = 10,
  parameter int unsigned TO_CYC  = 100
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [IDX_W-1:0] part_idx_i,
  input  logic             stat_sel_i,
  input  logic             tmr_exp_i,
  output logic             tmr_load_o,
  output logic [CNT_W-1:0] tmr_val_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             rst_o,
  output logic             tog_o,
  output logic             clk_en_o,
  output logic             uncl_o,
  output logic             done_o,
  output logic             err_o,
  output logic             busy_o
);
  localparam logic [CNT_W-1:0] SET_LD = CNT_W'(SET_CYC - 1);
  localparam logic [CNT_W-1:0] TO_LD  = CNT_W'(TO_CYC - 1);

  seq_state_e       state_q;
  logic [IDX_W-1:0] idx_q;
  logic             rst_q, tog_q, clk_q, uncl_q, done_q, err_q;

  always_comb begin
    tmr_load_o = 1'b0;
    tmr_val_o  = SET_LD;
    unique case (state_q)
      ST_CHECK: begin
        tmr_load_o = 1'b1;
        tmr_val_o  = stat_sel_i ? SET_LD : TO_LD;
      end
      ST_PWR:     tmr_load_o = stat_sel_i;
      ST_SET_CLK: tmr_load_o = tmr_exp_i;
      default:    tmr_load_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      rst_q   <= 1'b0;
      tog_q   <= 1'b0;
      clk_q   <= 1'b0;
      uncl_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      tog_q  <= 1'b0;
      clk_q  <= 1'b0;
      uncl_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          idx_q   <= part_idx_i;
          rst_q   <= 1'b1;
          state_q <= ST_CHECK;
        end
        ST_CHECK: begin
          if (stat_sel_i) begin
            clk_q   <= 1'b1;
            state_q <= ST_SET_CLK;
          end else begin
            tog_q   <= 1'b1;
            state_q <= ST_PWR;
          end
        end
        ST_PWR: begin
          if (stat_sel_i) begin
            clk_q   <= 1'b1;
            state_q <= ST_SET_CLK;
          end else if (tmr_exp_i) begin
            err_q   <= 1'b1;  // reset stays asserted
            state_q <= ST_IDLE;
          end
        end
        ST_SET_CLK: if (tmr_exp_i) begin
          uncl_q  <= 1'b1;
          state_q <= ST_SET_UNCL;
        end
        ST_SET_UNCL: if (tmr_exp_i) begin
          rst_q   <= 1'b0;
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign idx_o    = idx_q;
  assign rst_o    = rst_q;
  assign tog_o    = tog_q;
  assign clk_en_o = clk_q;
  assign uncl_o   = uncl_q;
  assign done_o   = done_q;
  assign err_o    = err_q;
  assign busy_o   = (state_q != ST_IDLE);
endmodule

// File: rtl/part_pwrup_seq.sv
module part_pwrup_seq #(
  parameter int unsigned NUM_PARTS   = 8,
  parameter int unsigned CLK_FREQ_HZ = 250_000_000,
  parameter int unsigned SETTLE_US   = 10,
  parameter int unsigned TIMEOUT_US  = 25_000,
  parameter int unsigned SWAP_A      = 3,
  parameter int unsigned SWAP_B      = 4,
  localparam int unsigned IDX_W      = (NUM_PARTS > 1) ? $clog2(NUM_PARTS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [IDX_W-1:0]     part_idx_i,
  input  logic [NUM_PARTS-1:0] part_stat_i,
  output logic [IDX_W-1:0]     part_o,
  output logic                 periph_rst_o,
  output logic                 toggle_req_o,
  output logic                 clk_en_o,
  output logic                 unclamp_req_o,
  output logic [NUM_PARTS-1:0] unclamp_mask_o,
  output logic                 busy_o,
  output logic                 done_o,
  output logic                 err_o
);
  localparam int unsigned CYC_PER_US = CLK_FREQ_HZ / 1_000_000;
  localparam int unsigned SET_RAW    = CYC_PER_US * SETTLE_US;
  localparam int unsigned TO_RAW     = CYC_PER_US * TIMEOUT_US;
  localparam int unsigned SET_CYC    = (SET_RAW > 0) ? SET_RAW : 1;
  localparam int unsigned TO_CYC     = (TO_RAW > 0) ? TO_RAW : 1;
  localparam int unsigned MAX_CYC    = (SET_CYC > TO_CYC) ? SET_CYC : TO_CYC;
  localparam int unsigned CNT_W      = $clog2(MAX_CYC + 1);

  logic             tmr_load, tmr_exp, stat_sel;
  logic [CNT_W-1:0] tmr_val;
  logic [IDX_W-1:0] idx;

  assign stat_sel = part_stat_i[idx];
  assign part_o   = idx;

  pwrup_ctrl #(
    .IDX_W(IDX_W), .CNT_W(CNT_W), .SET_CYC(SET_CYC), .TO_CYC(TO_CYC)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .part_idx_i (part_idx_i),
    .stat_sel_i (stat_sel),
    .tmr_exp_i  (tmr_exp),
    .tmr_load_o (tmr_load),
    .tmr_val_o  (tmr_val),
    .idx_o      (idx),
    .rst_o      (periph_rst_o),
    .tog_o      (toggle_req_o),
    .clk_en_o   (clk_en_o),
    .uncl_o     (unclamp_req_o),
    .done_o     (done_o),
    .err_o      (err_o),
    .busy_o     (busy_o)
  );

  pwrup_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .expired_o  (tmr_exp)
  );

  pwrup_clamp_map #(
    .NUM_PARTS(NUM_PARTS), .IDX_W(IDX_W), .SWAP_A(SWAP_A), .SWAP_B(SWAP_B)
  ) u_map (
    .idx_i  (idx),
    .mask_o (unclamp_mask_o)
  );
endmodule

// File: rtl/part_pwrup_seq_chk.sv
module part_pwrup_seq_chk #(
  parameter int unsigned NUM_PARTS = 8,
  parameter int unsigned IDX_W     = 3
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 start_i,
  input logic [NUM_PARTS-1:0] part_stat_i,
  input logic [IDX_W-1:0]     part_o,
  input logic                 periph_rst_o,
  input logic                 toggle_req_o,
  input logic                 clk_en_o,
  input logic                 unclamp_req_o,
  input logic [NUM_PARTS-1:0] unclamp_mask_o,
  input logic                 busy_o,
  input logic                 done_o,
  input logic                 err_o
);
  p_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> (busy_o && periph_rst_o));

  p_clk_after_pwr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_en_o |-> $past(part_stat_i[part_o]));

  p_err_keeps_rst_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (periph_rst_o && !busy_o));

  p_mask_onehot_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unclamp_req_o |-> ($countones(unclamp_mask_o) == 1));

  p_done_release_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!periph_rst_o && !busy_o));

  p_busy_idx_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> $stable(part_o));

  p_tog_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    toggle_req_o |=> !toggle_req_o);

  p_uncl_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unclamp_req_o |=> !unclamp_req_o);

  p_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({toggle_req_o, clk_en_o, unclamp_req_o, done_o, err_o}));
endmodule

bind part_pwrup_seq part_pwrup_seq_chk #(
  .NUM_PARTS(NUM_PARTS), .IDX_W(IDX_W)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .start_i        (start_i),
  .part_stat_i    (part_stat_i),
  .part_o         (part_o),
  .periph_rst_o   (periph_rst_o),
  .toggle_req_o   (toggle_req_o),
  .clk_en_o       (clk_en_o),
  .unclamp_req_o  (unclamp_req_o),
  .unclamp_mask_o (unclamp_mask_o),
  .busy_o         (busy_o),
  .done_o         (done_o),
  .err_o          (err_o)
);

// File: tb/tb_part_pwrup_seq.sv
`timescale 1ns/1ps
module tb_part_pwrup_seq;
  localparam int NP  = 8;
  localparam int IW  = 3;
  localparam int MHZ = 2;   // count parameter only, not the bench clock
  localparam int SU  = 10;
  localparam int TU  = 100;
  localparam int S   = MHZ * SU;
  localparam int T   = MHZ * TU;
  localparam int SA  = 3;
  localparam int SB  = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [IW-1:0] idx_in = '0;
  logic [NP-1:0] stat = '0;
  logic [IW-1:0] part;
  logic          prst, tog, clken, uncl, busy, done, err;
  logic [NP-1:0] mask;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  part_pwrup_seq #(
    .NUM_PARTS(NP), .CLK_FREQ_HZ(MHZ * 1_000_000), .SETTLE_US(SU),
    .TIMEOUT_US(TU), .SWAP_A(SA), .SWAP_B(SB)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .part_idx_i(idx_in),
    .part_stat_i(stat), .part_o(part), .periph_rst_o(prst),
    .toggle_req_o(tog), .clk_en_o(clken), .unclamp_req_o(uncl),
    .unclamp_mask_o(mask), .busy_o(busy), .done_o(done), .err_o(err)
  );

  function automatic logic [NP-1:0] exp_mask(input int i);
    int b;
    b = (i == SA) ? SB : (i == SB) ? SA : i;
    return NP'(1) << b;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // lat: cycles from toggle to status rising; -1 = never
  task automatic run(input int i, input bit pre, input int lat,
                     input int inj_cyc, input int inj_idx);
    int cyc, n_tog, n_clk, n_unc, n_done, n_err;
    int c_tog, c_clk, c_unc, c_done, c_err;
    int e_clk, e_err;
    bit rst_ok, idx_ok;
    logic [NP-1:0] m_seen;
    bit ok_path;
    stat = NP'($urandom);
    stat[i] = pre;
    @(negedge clk);
    start = 1'b1; idx_in = IW'(i);
    @(negedge clk);
    start = 1'b0; idx_in = IW'($urandom);
    chk(busy && prst && part == IW'(i), "R2 start", {busy, prst}, 3);
    cyc = 0;
    n_tog = 0; n_clk = 0; n_unc = 0; n_done = 0; n_err = 0;
    c_tog = -1; c_clk = -1; c_unc = -1; c_done = -1; c_err = -1;
    rst_ok = 1'b1; idx_ok = 1'b1; m_seen = '0;
    if (inj_cyc == 0) begin start = 1'b1; idx_in = IW'(inj_idx); end
    while (busy && cyc < T + 2 * S + 20) begin
      @(negedge clk);
      cyc++;
      start = 1'b0;
      if (tog)   begin n_tog++;  c_tog = cyc; end
      if (clken) begin n_clk++;  c_clk = cyc; end
      if (uncl)  begin n_unc++;  c_unc = cyc; m_seen = mask; end
      if (done)  begin n_done++; c_done = cyc; end
      if (err)   begin n_err++;  c_err = cyc; end
      if (!done && !prst) rst_ok = 1'b0;
      if (part != IW'(i)) idx_ok = 1'b0;
      if (c_tog > 0 && lat >= 0 && cyc == c_tog + lat) stat[i] = 1'b1;
      if (cyc == inj_cyc) begin start = 1'b1; idx_in = IW'(inj_idx); end
    end
    start = 1'b0;
    ok_path = pre || (lat >= 0 && lat <= T - 1);
    e_clk = pre ? 1 : 2 + lat;
    e_err = 1 + T;
    chk(n_tog == (pre ? 0 : 1), pre ? "R3 no toggle" : "R4 one toggle", n_tog, pre ? 0 : 1);
    if (!pre) chk(c_tog == 1, "R4 toggle cycle", c_tog, 1);
    chk(idx_ok, "R9 index held", part, i);
    if (ok_path) begin
      chk(n_clk == 1 && c_clk == e_clk, pre ? "R3 clk_en cycle" : "R4 clk_en cycle", c_clk, e_clk);
      chk(n_unc == 1 && c_unc == e_clk + S, "R6 unclamp cycle", c_unc, e_clk + S);
      chk(m_seen == exp_mask(i), "R7 unclamp mask", m_seen, exp_mask(i));
      chk(n_done == 1 && c_done == e_clk + 2 * S && n_err == 0, "R8 done cycle", c_done, e_clk + 2 * S);
      chk(rst_ok && !prst, "R8 reset release", prst, 0);
    end else begin
      chk(n_err == 1 && c_err == e_err, "R5 timeout cycle", c_err, e_err);
      chk(n_clk == 0 && n_unc == 0 && n_done == 0, "R5 no clk/unclamp", n_clk + n_unc, 0);
      chk(prst, "R5 reset kept", prst, 1);
    end
    chk(!busy, "R10 idle after end", busy, 0);
    repeat (3) @(negedge clk);
    chk(!busy && !tog && !clken && !uncl && !done && !err, "R9 late start ignored", busy, 0);
    chk(prst == !ok_path, "R5/R8 reset level held", prst, !ok_path);
  endtask

  initial begin
    #(4 * 200_000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(!busy && !prst && !tog && !clken && !uncl && !done && !err, "R1 reset state",
        {busy, prst, tog, clken, uncl, done, err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !prst, "R1 after release", {busy, prst}, 0);
    run(0, 1'b1, 0, 1000, 0);        // R3 already powered
    run(1, 1'b0, 0, 1000, 0);        // R4 earliest status
    run(2, 1'b0, T - 1, 1000, 0);    // R4 last cycle in window
    run(5, 1'b0, T, 1000, 0);        // R5 one cycle late
    run(6, 1'b0, -1, 1000, 0);       // R5 never
    run(SA, 1'b0, 7, 1000, 0);       // R7 swap
    run(SB, 1'b1, 0, 1000, 0);       // R7 swap
    run(7, 1'b0, 3, 0, 2);           // R9 start during check
    run(1, 1'b0, 5, 10, 6);          // R9 start during settle
    for (int k = 0; k < 20; k++) begin
      int r, lt;
      r = $urandom % 8;
      lt = (r == 0) ? -1 : int'($urandom % (T + 10));
      run(int'($urandom % NP), (r == 1), lt, int'($urandom % 60), int'($urandom % NP));
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule